// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the address for each beat of a four-beat burst. A load pulse captures a full base address together with the ordering mode. The upper address bits are then held for the whole burst, while the two low bits are generated from an internal beat counter. The counter steps only when the active-low advance input is asserted, so holding advance high turns the cycle into a wait that repeats the current address.

Two orderings are available. Linear ordering counts the low bits upward modulo four from the loaded offset. Interleaved ordering takes the loaded offset XOR the beat count. Both orders stay inside the aligned group of four, and advancing past the fourth beat returns to the first address. The mode input is meant to stay static, and the block reads it only when a load occurs.

Control is a three-state machine:
- `ST_IDLE` is entered at reset. In this state nothing has been loaded and advance is ignored.
- `ST_RUN` means the current beat was presented through a load or an advance.
- `ST_HOLD` means the last cycle was a wait.

The transitions are as follows:
- Load moves any state to `ST_RUN`.
- From `ST_RUN` or `ST_HOLD`, advance low goes to `ST_RUN`.
- From `ST_RUN` or `ST_HOLD`, advance high goes to `ST_HOLD`.
- Without a load, `ST_IDLE` stays in `ST_IDLE`.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `addr_o` is 0 and `beat_o` is 0. Until the first load, advance pulses leave both unchanged.
- R2: A load edge captures `base_addr`. In the following cycle `addr_o` equals the captured address and `beat_o` is 0.
- R3: When `mode_sel`=0 at load (linear), `addr_o[1:0]` equals (loaded offset + `beat_o`) mod 4.
- R4: When `mode_sel`=1 at load (interleaved), `addr_o[1:0]` equals the loaded offset XOR `beat_o`.
- R5: An edge with `adv_n`=0 and no load, after a first load, increments `beat_o` by one mod 4. The fifth address of a burst therefore equals the first.
- R6: An edge with `adv_n`=1 and no load keeps `addr_o` and `beat_o` unchanged (wait cycle).
- R7: Load takes priority over advance on the same edge and restarts at beat 0, including in the middle of a burst.
- R8: `addr_o[ADDR_W-1:2]` equals the loaded base's upper bits for the whole burst.
- R9: `mode_sel` is sampled only at load. Changing it between loads does not alter the order in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | Ordering mode, 0 = linear, 1 = interleaved, read at load |
| load | input | 1 | Capture a new base address and restart the burst |
| base_addr | input | ADDR_W | External base address |
| adv_n | input | 1 | Active-low advance; high produces a wait cycle |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat index 0..3 |

## Verification
The bench starts bursts at each of the four low offsets in both modes. It advances five times so that the wrap back to the first address is observed. Offsets 1 and 3 separate XOR from addition, and offset 0 shows the two orders agree. Wait cycles placed mid-burst separate a suspend from a step. A load that coincides with advance, in the middle of a burst, shows which of the two wins. Toggling the mode between loads, and pulsing advance before any load, show that those inputs are ignored.

// File: rtl/bas_pkg.sv
package bas_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_t;
endpackage

// File: rtl/bas_beat_fsm.sv
module bas_beat_fsm
    import bas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv_n,
    output logic [BEAT_W-1:0] beat,
    output seq_state_t        state
);
    seq_state_t        state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN:  state_d = adv_n ? ST_HOLD : ST_RUN;
                ST_HOLD: state_d = adv_n ? ST_HOLD : ST_RUN;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        beat_d = beat_q;
        if (load) begin
            beat_d = '0;
        end else if (state_q != ST_IDLE && !adv_n) begin
            beat_d = beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign beat  = beat_q;
    assign state = state_q;
endmodule

// File: rtl/bas_base_reg.sv
module bas_base_reg
    import bas_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              mode_sel,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] base_q,
    output order_t            order_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_INTERLEAVE;
        end else if (load) begin
            base_q  <= base_addr;
            order_q <= order_t'(mode_sel);
        end
    end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
    import bas_pkg::*;
(
    input  logic [BEAT_W-1:0] offset,
    input  logic [BEAT_W-1:0] beat,
    input  order_t            order,
    output logic [BEAT_W-1:0] low_addr
);
    always_comb begin
        unique case (order)
            ORD_LINEAR:     low_addr = offset + beat;
            ORD_INTERLEAVE: low_addr = offset ^ beat;
            default:        low_addr = offset;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              adv_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        beat_o
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    order_t            order_q;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low_addr;
    seq_state_t        state;

    bas_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .mode_sel (mode_sel),
        .base_addr(base_addr),
        .base_q   (base_q),
        .order_q  (order_q)
    );

    bas_beat_fsm u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .adv_n(adv_n),
        .beat (beat),
        .state(state)
    );

    bas_order_map u_map (
        .offset  (base_q[BEAT_W-1:0]),
        .beat    (beat),
        .order   (order_q),
        .low_addr(low_addr)
    );

    logic [UPPER_W-1:0] upper_bits;
    assign upper_bits = base_q[ADDR_W-1:BEAT_W];

    always_comb begin
        addr_o = {upper_bits, low_addr};
        beat_o = beat;
    end

    logic unused_state;
    assign unused_state = ^state;
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              adv_n,
    input logic [ADDR_W-1:0] base_addr,
    input logic [ADDR_W-1:0] addr_o,
    input logic [1:0]        beat_o
);
    logic seen_load;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_load <= 1'b0;
        else if (load) seen_load <= 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_load && !load) |=> (addr_o == '0 && beat_o == 2'd0)); // R1
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_o == $past(base_addr) && beat_o == 2'd0)); // R2
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_load && !load && !adv_n) |=> (beat_o == $past(beat_o) + 2'd1)); // R5
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> ($stable(addr_o) && $stable(beat_o))); // R6
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !adv_n) |=> (beat_o == 2'd0)); // R7
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_o[ADDR_W-1:2])); // R8
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .adv_n    (adv_n),
    .base_addr(base_addr),
    .addr_o   (addr_o),
    .beat_o   (beat_o)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_sel = 1'b0;
    logic          load = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr_o;
    logic [1:0]    beat_o;

    burst_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .load(load),
        .base_addr(base_addr), .adv_n(adv_n), .addr_o(addr_o), .beat_o(beat_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    beat;
        string         tag;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_mode = 1'b1;
    bit            m_loaded = 0;

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        lo = m_mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic step(input logic ld, input logic [AW-1:0] b, input logic m,
                        input logic an, input string tag);
        exp_t e;
        @(negedge clk);
        load = ld; base_addr = b; mode_sel = m; adv_n = an;
        @(posedge clk);
        if (ld) begin
            m_base = b; m_mode = m; m_cnt = 2'd0; m_loaded = 1;
        end else if (!an && m_loaded) begin
            m_cnt = m_cnt + 2'd1;
        end
        e.addr = model_addr();
        e.beat = m_cnt;
        e.tag  = tag;
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                n_cmp++;
                if (addr_o !== e.addr || beat_o !== e.beat) begin
                    n_bad++;
                    $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                             e.tag, addr_o, beat_o, e.addr, e.beat);
                end
            end
        end
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        logic [AW-1:0] b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (addr_o !== '0 || beat_o !== 2'd0) begin
            n_bad++;
            $display("FAIL R1 reset: addr=%h beat=%0d expected 0000/0", addr_o, beat_o);
        end
        rst_n = 1'b1;
        // R1: advance before any load is ignored
        step(1'b0, 16'hFFFF, 1'b1, 1'b0, "R1 adv before load");
        step(1'b0, 16'h1234, 1'b0, 1'b0, "R1 adv before load");

        // R3 linear and R4 interleaved: every offset, full wrap, mid-burst waits
        for (int md = 0; md < 2; md++) begin
            for (int off = 0; off < 4; off++) begin
                b = {14'(16'h2A5C + off * 16'h0133 + md * 16'h0F00), 2'(off)};
                step(1'b1, b, 1'(md), 1'b1, "R2 load");
                step(1'b0, b, 1'(md), 1'b0, md ? "R4 beat1" : "R3 beat1");
                step(1'b0, b, 1'(md), 1'b1, "R6 wait");
                step(1'b0, b, 1'(md), 1'b1, "R6 wait");
                step(1'b0, b, 1'(md), 1'b0, md ? "R4 beat2" : "R3 beat2");
                step(1'b0, b, 1'(md), 1'b0, md ? "R4 beat3" : "R3 beat3");
                step(1'b0, b, 1'(md), 1'b0, "R5 wrap to first");
                step(1'b0, b, 1'(md), 1'b0, "R5 after wrap");
            end
        end

        // R7: load with advance mid-burst
        step(1'b1, 16'h8001, 1'b0, 1'b1, "R2 load");
        step(1'b0, 16'h0000, 1'b0, 1'b0, "R3 beat1");
        step(1'b1, 16'h4C03, 1'b1, 1'b0, "R7 load wins");
        step(1'b0, 16'h0000, 1'b1, 1'b0, "R7 restart beat1");

        // R9: mode toggled between loads is ignored; R8 upper bits held
        step(1'b1, 16'hBEE1, 1'b0, 1'b1, "R2 load");
        step(1'b0, 16'h0000, 1'b1, 1'b0, "R9 mode ignored");
        step(1'b0, 16'hFFFF, 1'b1, 1'b0, "R9 mode ignored");
        step(1'b0, 16'h5555, 1'b0, 1'b1, "R8 upper held");
        step(1'b0, 16'h5555, 1'b1, 1'b0, "R8 upper held");

        step(1'b0, 16'h0000, 1'b0, 1'b1, "R6 idle tail");
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule